// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block is the timekeeping core of a real-time clock. A 128 Hz tick from an external prescaler feeds a 7-bit binary sub-second counter. Each time that counter wraps, a packed-BCD counter chain advances: seconds, minutes, hours (24-hour), weekday, day of month, month and year. Month lengths follow the calendar. February has 29 days whenever the BCD year within the century is a multiple of four.

Software reaches the block through a single synchronous register bus. Writes are captured on the clock edge and reads are combinational from the address. Register k sits at byte address k × `REG_STRIDE`. Two control registers hold the run controls, the prescaler reset, a 30-second adjust request, a carry flag and its interrupt enable. The carry flag is raised on every seconds advance, so software can clear it, read the time registers and then check that no rollover split the read. A parameter selects a 16-bit four-digit year (century in the upper byte) or a two-digit year.

Register indices: 0 sub-second, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 day, 6 month, 7 year, 14 control A, 15 control B.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the sub-second, seconds, minutes, hours, weekday and year registers read 0. Day and month read 0x01. Both control registers read 0 and `carry_irq_o` is low.
- R2: The sub-second counter advances by one on each clock edge with `tick_i` high, but only while control B has start (bit 0) = 1, enable (bit 3) = 1 and prescaler reset (bit 1) = 0. Otherwise it holds its value.
- R3: When the sub-second counter wraps from 127 to 0, seconds advance. BCD seconds and minutes roll over from 0x59 to 0x00 and carry onward. Hours roll over from 0x23 to 0x00 and carry into both day and weekday.
- R4: The weekday counts 0 to 6 and wraps from 6 to 0 on a day carry.
- R5: The day wraps to 0x01 after the last day of the month and carries into the month. Months 4, 6, 9 and 11 have 30 days and February has 28 or 29. The month wraps from 0x12 to 0x01 and carries into the year.
- R6: In four-digit mode the year is 16 bits: 0x0099 rolls to 0x0100 and 0x9999 rolls to 0x0000. In two-digit mode 0x99 rolls to 0x00 and bits 15:8 read 0.
- R7: Writes to time registers 1 to 7 take effect only while start is 0 and are ignored while start is 1. The sub-second register is never writable.
- R8: Control A bit 7 (carry flag) is set on every seconds advance, including an adjust. Writing 0 to bit 7 clears it and writing 1 leaves it unchanged. A set in the same cycle as a clearing write wins.
- R9: `carry_irq_o` is high exactly when the carry flag and control A bit 4 (carry interrupt enable) are both 1.
- R10: While control B bit 1 is 1, the sub-second counter is held at 0 and no counting takes place. Writing this bit as 1 clears the counter in that cycle.
- R11: Writing control B with bit 2 set performs an adjust, whatever the run state. Seconds and the sub-second counter become 0. If seconds were 0x30 or more, the minutes advance with full carry. Bit 2 always reads 0.
- R12: Only addresses that are a multiple of `REG_STRIDE` and map to indices 0 to 7, 14 or 15 decode. Any other address reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 128 Hz tick from the prescaler, one cycle per tick |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address (index × REG_STRIDE) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| carry_irq_o | output | 1 | Carry interrupt |

## Verification
The counter chain is driven from calendar states placed a few seconds before a boundary. These include a leap and a non-leap February, a 30-day month, the end of a year and of a century, and 9999. Each case shows whether the cascade and the month-length decode pick the right rollover point. Random starting times sit near the end of a minute, an hour and a month with random tick counts. They are compared against a binary calendar model in the bench, which catches slips between BCD digits and carries that the directed cases miss. Directed sequences cover the run gating, the locked writes, the adjust on each side of 30 seconds, and a flag-clear write that lands in the same cycle as a rollover.

// File: rtl/bcd_rtc_core.sv
`timescale 1ns/1ps
module bcd_rtc_core #(
  parameter int REG_STRIDE      = 2,
  parameter bit FOUR_DIGIT_YEAR = 1'b1,
  parameter int SUB_W           = 7,
  localparam int ADDR_W         = $clog2(16 * REG_STRIDE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic              carry_irq_o
);

  localparam logic [SUB_W-1:0] SUB_MAX = {SUB_W{1'b1}};
  localparam logic [3:0] I_SUB = 4'd0,  I_SEC = 4'd1, I_MIN = 4'd2, I_HR = 4'd3,
                         I_WK  = 4'd4,  I_DAY = 4'd5, I_MON = 4'd6, I_YR = 4'd7,
                         I_CA  = 4'd14, I_CB  = 4'd15;

  logic [SUB_W-1:0] sub;
  logic [7:0] sec, mins, hr, wk, day, mon, yr_lo, yr_hi;
  logic cf, cie, en, pre_rst, start;

  logic [3:0] idx;
  logic hit, tw, wr_ca, wr_cb, adj;
  logic run, step, sub_wrap;
  logic inc_sec, inc_min, inc_hr, inc_day, inc_mon, inc_yr, inc_cent;
  logic leap;
  logic [7:0] mon_len;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'h0} : v + 8'd1;
  endfunction

  assign idx   = 4'(addr_i / ADDR_W'(REG_STRIDE));
  assign hit   = (addr_i % ADDR_W'(REG_STRIDE)) == '0;
  assign tw    = wr_en_i && hit && !start;
  assign wr_ca = wr_en_i && hit && idx == I_CA;
  assign wr_cb = wr_en_i && hit && idx == I_CB;
  assign adj   = wr_cb && wdata_i[2];

  assign run      = start && en && !pre_rst;
  assign step     = run && tick_i;
  assign sub_wrap = step && sub == SUB_MAX;

  assign inc_sec  = sub_wrap && !adj;
  assign inc_min  = (inc_sec && sec >= 8'h59) || (adj && sec >= 8'h30);
  assign inc_hr   = inc_min && mins >= 8'h59;
  assign inc_day  = inc_hr && hr >= 8'h23;
  assign inc_mon  = inc_day && day >= mon_len;
  assign inc_yr   = inc_mon && mon >= 8'h12;
  assign inc_cent = inc_yr && yr_lo >= 8'h99;

  assign leap = yr_lo[4] ? (yr_lo[3:0] == 4'd2 || yr_lo[3:0] == 4'd6)
                         : (yr_lo[3:0] == 4'd0 || yr_lo[3:0] == 4'd4 || yr_lo[3:0] == 4'd8);

  always_comb begin
    case (mon)
      8'h02:                      mon_len = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: mon_len = 8'h30;
      default:                    mon_len = 8'h31;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       sub <= '0;
    else if (adj || pre_rst)          sub <= '0;
    else if (wr_cb && wdata_i[1])     sub <= '0;
    else if (step)                    sub <= sub + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec <= '0; mins <= '0; hr <= '0; wk <= '0;
      day <= 8'h01; mon <= 8'h01; yr_lo <= '0;
    end else begin
      if (adj)                         sec <= '0;
      else if (tw && idx == I_SEC)     sec <= wdata_i[7:0];
      else if (inc_sec)                sec <= (sec >= 8'h59) ? 8'h00 : bcd_inc(sec);

      if (tw && idx == I_MIN)          mins <= wdata_i[7:0];
      else if (inc_min)                mins <= (mins >= 8'h59) ? 8'h00 : bcd_inc(mins);

      if (tw && idx == I_HR)           hr <= wdata_i[7:0];
      else if (inc_hr)                 hr <= (hr >= 8'h23) ? 8'h00 : bcd_inc(hr);

      if (tw && idx == I_WK)           wk <= wdata_i[7:0];
      else if (inc_day)                wk <= (wk >= 8'h06) ? 8'h00 : wk + 8'd1;

      if (tw && idx == I_DAY)          day <= wdata_i[7:0];
      else if (inc_day)                day <= (day >= mon_len) ? 8'h01 : bcd_inc(day);

      if (tw && idx == I_MON)          mon <= wdata_i[7:0];
      else if (inc_mon)                mon <= (mon >= 8'h12) ? 8'h01 : bcd_inc(mon);

      if (tw && idx == I_YR)           yr_lo <= wdata_i[7:0];
      else if (inc_yr)                 yr_lo <= (yr_lo >= 8'h99) ? 8'h00 : bcd_inc(yr_lo);
    end
  end

  if (FOUR_DIGIT_YEAR) begin : g_century
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      yr_hi <= '0;
      else if (tw && idx == I_YR)      yr_hi <= wdata_i[15:8];
      else if (inc_cent)               yr_hi <= (yr_hi >= 8'h99) ? 8'h00 : bcd_inc(yr_hi);
    end
  end else begin : g_two_digit
    assign yr_hi = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cf <= 1'b0; cie <= 1'b0; en <= 1'b0; pre_rst <= 1'b0; start <= 1'b0;
    end else begin
      if (inc_sec || adj)              cf <= 1'b1;
      else if (wr_ca && !wdata_i[7])   cf <= 1'b0;
      if (wr_ca)                       cie <= wdata_i[4];
      if (wr_cb) begin
        en      <= wdata_i[3];
        pre_rst <= wdata_i[1];
        start   <= wdata_i[0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      case (idx)
        I_SUB:   rdata_o = 16'(sub);
        I_SEC:   rdata_o = {8'h00, sec};
        I_MIN:   rdata_o = {8'h00, mins};
        I_HR:    rdata_o = {8'h00, hr};
        I_WK:    rdata_o = {8'h00, wk};
        I_DAY:   rdata_o = {8'h00, day};
        I_MON:   rdata_o = {8'h00, mon};
        I_YR:    rdata_o = {yr_hi, yr_lo};
        I_CA:    rdata_o = {8'h00, cf, 2'b00, cie, 4'h0};
        I_CB:    rdata_o = {8'h00, 4'h0, en, 1'b0, pre_rst, start};
        default: rdata_o = '0;
      endcase
    end
  end

  assign carry_irq_o = cf && cie;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !wr_cb) |=> $stable(sub));

  p_sub_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sub_wrap |=> (sub == '0));

  p_weekday_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_day && wk == 8'h06) |=> (wk == 8'h00));

  p_locked_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && wr_en_i && hit && idx == I_SEC && !inc_sec) |=> $stable(sec));

  p_carry_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inc_sec |=> cf);

  p_carry_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ca && !wdata_i[7] && !inc_sec) |=> !cf);

  p_adjust_r11: assert property (@(posedge clk) disable iff (!rst_n)
    adj |=> (sec == 8'h00 && sub == '0 && cf));

endmodule

// File: tb/bcd_rtc_core_tb.sv
`timescale 1ns/1ps
module bcd_rtc_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int STRIDE = 2;
  localparam int AW = $clog2(16 * STRIDE);

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0, rdata, rdata2;
  logic irq, irq2;

  int checks = 0, failures = 0;
  bit finished = 1'b0;
  int msub, ms, mm, mh, mw, md, mmo, my;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_rtc_core #(.REG_STRIDE(STRIDE), .FOUR_DIGIT_YEAR(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .carry_irq_o(irq));

  bcd_rtc_core #(.REG_STRIDE(STRIDE), .FOUR_DIGIT_YEAR(1'b0)) dut2_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata2), .carry_irq_o(irq2));

  function automatic logic [7:0] b(input int v);
    return 8'(((v / 10) % 10) * 16 + v % 10);
  endfunction

  function automatic int mlen(input int mo, input int y);
    case (mo)
      2: return ((y % 100) % 4 == 0) ? 29 : 28;
      4, 6, 9, 11: return 30;
      default: return 31;
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic wr_raw(input int a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr(input int i, input logic [15:0] d);
    wr_raw(i * STRIDE, d);
  endtask

  task automatic rd_raw(input int a, output logic [15:0] v, output logic [15:0] v2);
    @(negedge clk); addr = AW'(a); #1; v = rdata; v2 = rdata2;
  endtask

  task automatic rd(input int i, output logic [15:0] v);
    logic [15:0] t2;
    rd_raw(i * STRIDE, v, t2);
  endtask

  task automatic model_sec();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0; mw = (mw + 1) % 7; md++;
          if (md > mlen(mmo, my)) begin
            md = 1; mmo++;
            if (mmo == 13) begin mmo = 1; my = (my + 1) % 10000; end
          end
        end
      end
    end
  endtask

  task automatic advance(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
    for (int k = 0; k < n; k++) begin
      msub++;
      if (msub == 128) begin msub = 0; model_sec(); end
    end
  endtask

  task automatic set_time(input int y, input int mo, input int d, input int w,
                          input int h, input int mi, input int s);
    my = y; mmo = mo; md = d; mw = w; mh = h; mm = mi; ms = s; msub = 0;
    wr(15, 16'h0002);
    wr(1, {8'h00, b(s)}); wr(2, {8'h00, b(mi)}); wr(3, {8'h00, b(h)});
    wr(4, {8'h00, b(w)}); wr(5, {8'h00, b(d)}); wr(6, {8'h00, b(mo)});
    wr(7, {b(y / 100), b(y % 100)});
    wr(15, 16'h0009);
  endtask

  task automatic check_time(input string req);
    logic [15:0] v, v2;
    rd(0, v); chk({req, " sub"}, v, 16'(msub));
    rd(1, v); chk({req, " sec"}, v, {8'h00, b(ms)});
    rd(2, v); chk({req, " min"}, v, {8'h00, b(mm)});
    rd(3, v); chk({req, " hour"}, v, {8'h00, b(mh)});
    rd(4, v); chk({req, " wday"}, v, {8'h00, b(mw)});
    rd(5, v); chk({req, " day"}, v, {8'h00, b(md)});
    rd(6, v); chk({req, " month"}, v, {8'h00, b(mmo)});
    rd_raw(7 * STRIDE, v, v2);
    chk({req, " year4"}, v, {b(my / 100), b(my % 100)});
    chk({req, " year2"}, v2, {8'h00, b(my % 100)});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog timeout");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v2;
    void'($urandom(32'd20240229));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    my = 0; mmo = 1; md = 1; mw = 0; mh = 0; mm = 0; ms = 0; msub = 0;
    check_time("R1");
    rd(14, v); chk("R1 ctlA", v, 16'h0000);
    rd(15, v); chk("R1 ctlB", v, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);

    // R2 run gating
    wr(15, 16'h0001); advance(50); msub = 0;
    rd(0, v); chk("R2 start without enable", v, 16'h0000);
    wr(15, 16'h0009); advance(50);
    rd(0, v); chk("R2 running", v, 16'd50);
    wr(15, 16'h0008); @(negedge clk); tick = 1'b1; repeat (10) @(negedge clk); tick = 1'b0;
    rd(0, v); chk("R2 stopped holds", v, 16'd50);

    // R12 decode
    rd_raw(1, v, v2); chk("R12 misaligned read", v, 16'h0000);
    rd(9, v); chk("R12 unused index", v, 16'h0000);
    wr_raw(1 * STRIDE + 1, 16'h0042);
    rd(1, v); chk("R12 misaligned write ignored", v, 16'h0000);

    // R7 locked writes
    wr(15, 16'h0009);
    wr(1, 16'h0033); rd(1, v); chk("R7 locked while started", v, 16'h0000);
    wr(0, 16'h0011); rd(0, v); chk("R7 sub read-only", v, 16'd50);
    wr(15, 16'h0008);
    wr(1, 16'h0033); rd(1, v); chk("R7 write while stopped", v, 16'h0033);

    // R8 / R9 carry flag and interrupt
    wr(14, 16'h0000);
    set_time(2010, 5, 10, 3, 12, 30, 10);
    advance(128);
    rd(14, v); chk("R8 flag set", v, 16'h0080);
    chk("R9 irq masked", {15'd0, irq}, 16'h0000);
    wr(14, 16'h0090); rd(14, v); chk("R8 write one keeps", v, 16'h0090);
    chk("R9 irq asserted", {15'd0, irq}, 16'h0001);
    wr(14, 16'h0010); rd(14, v); chk("R8 write zero clears", v, 16'h0010);
    chk("R9 irq cleared", {15'd0, irq}, 16'h0000);
    advance(127);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = AW'(14 * STRIDE); wdata = 16'h0010;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    msub = 0; model_sec();
    rd(14, v); chk("R8 set wins over clear", v, 16'h0090);
    check_time("R3 after collision");
    wr(14, 16'h0000);

    // R10 prescaler reset
    advance(20);
    wr(15, 16'h000B); msub = 0;
    rd(0, v); chk("R10 cleared", v, 16'h0000);
    @(negedge clk); tick = 1'b1; repeat (30) @(negedge clk); tick = 1'b0;
    rd(0, v); chk("R10 held", v, 16'h0000);
    rd(15, v); chk("R10 ctlB readback", v, 16'h000B);
    wr(15, 16'h0009); advance(5);
    check_time("R10 resumed");

    // R11 adjust
    set_time(2031, 12, 31, 6, 23, 59, 45);
    advance(40);
    wr(15, 16'h000D); msub = 0; ms = 59; model_sec();
    check_time("R11 adjust carry");
    rd(15, v); chk("R11 bit self clears", v, 16'h0009);
    rd(14, v); chk("R11 flag", v, 16'h0080);
    set_time(2031, 6, 15, 2, 8, 20, 29);
    advance(3);
    wr(15, 16'h0005); msub = 0; ms = 0;
    check_time("R11 adjust below 30");

    // Calendar corners: R3 R4 R5 R6
    set_time(2024, 2, 28, 6, 23, 59, 59); advance(128); check_time("R5 leap Feb");
    set_time(2023, 2, 28, 6, 23, 59, 59); advance(128); check_time("R5 R4 plain Feb");
    set_time(2023, 4, 30, 1, 23, 59, 59); advance(128); check_time("R5 30-day month");
    set_time(1999, 12, 31, 5, 23, 59, 59); advance(128); check_time("R6 century");
    set_time(99, 12, 31, 2, 23, 59, 59); advance(128); check_time("R6 year 0099");
    set_time(9999, 12, 31, 4, 23, 59, 59); advance(128); check_time("R6 year wrap");
    set_time(2000, 2, 29, 0, 23, 59, 58); advance(256); check_time("R5 year 00 leap");

    // Random near-boundary times
    for (int it = 0; it < 20; it++) begin
      int y, mo, d;
      y = $urandom % 10000; mo = 1 + $urandom % 12;
      d = mlen(mo, y) - int'($urandom % 2);
      set_time(y, mo, d, $urandom % 7, 22 + $urandom % 2, 57 + $urandom % 3, 55 + $urandom % 5);
      advance(128 * (1 + $urandom % 4) + $urandom % 128);
      check_time("R3 R5 R6 random");
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule